// File: doc/BRIEF.md
# Hierarchical DMA Transfer Sequencer

This block is the address engine of one DMA channel. A transfer is split into three nested units. A transaction is a run of blocks, and a block is a run of fragments. The lengths of all three units are byte counts. The engine walks the source and destination addresses one beat at a time. It adds a per-beat step to each address, and either side can be held at a fixed address. It raises a one-cycle done pulse whenever a fragment, a block or the transaction ends.

Work is started through a request handshake. The request carries a two-bit mode that sets how far the engine runs before it stops and waits for the next request: one fragment, one block, or the rest of the transaction. Requests that arrive while a transaction is unfinished resume where the previous request stopped. Configuration is sampled only on the request that opens a new transaction.

Beats leave on a valid/ready stream. While `beat_ready` is low, the current beat is held unchanged and no counter or address moves. `req_ready` is low for as long as a request is being served.

Top module: `dma_hier_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `beat_valid` is 0, all done outputs are 0 and `cur_dst` is 0.
- R2: `req_mode` 0 runs one fragment, 1 runs up to the end of the current block, and 2 runs up to the end of the transaction. Code 3 behaves as 2. The request finishes on the first beat whose done level reaches the requested level. `req_done` pulses at that point and `beat_valid` stays low until the next request.
- R3: The first beat of a transaction uses `cfg_src_base` and `cfg_dst_base`. Each accepted beat adds the source step (`cfg_step[15:0]`) and the destination step (`cfg_step[31:16]`), both zero-extended, modulo 2^32.
- R4: Each beat consumes 1, 2 or 4 bytes for `cfg_src_width` codes 0, 1 and 2 respectively. Code 3 also consumes 4 bytes.
- R5: A fragment ends after `cfg_frag_len` bytes or when its block ends. A block ends after `cfg_blk_len` bytes or when the transaction ends. The transaction ends after `cfg_txn_len` bytes, so a trailing block or fragment is shortened to fit.
- R6: Each done pulse is high for the single cycle after the handshake of the beat that ended the unit. The final beat of a transaction raises `frag_done`, `blk_done` and `txn_done` together.
- R7: With `cfg_hold_en` set, `cfg_hold_sel` 0 keeps the source address constant and 1 keeps the destination address constant.
- R8: Configuration is captured only when a request opens a new transaction. Changes to configuration inputs in the middle of a transaction have no effect on addresses, steps or lengths until the next transaction.
- R9: While `beat_valid` is high and `beat_ready` is low, the beat and its addresses hold steady. `req_ready` is low while a request is running and high again in the cycle `req_done` is high.
- R10: `cur_dst` always shows the destination address of the next beat, so it reports transfer progress.
- R11: `beat_src_size` and `beat_dst_size` carry the width codes captured at the start of the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken on this edge |
| req_mode | input | 2 | Request granularity: 0 fragment, 1 block, 2/3 transaction |
| cfg_src_base | input | 32 | Source start address |
| cfg_dst_base | input | 32 | Destination start address |
| cfg_src_width | input | 2 | Source width code (sets bytes per beat) |
| cfg_dst_width | input | 2 | Destination width code |
| cfg_step | input | 32 | Destination step in [31:16], source step in [15:0] |
| cfg_frag_len | input | 17 | Fragment length in bytes |
| cfg_blk_len | input | 17 | Block length in bytes |
| cfg_txn_len | input | 28 | Transaction length in bytes |
| cfg_hold_en | input | 1 | Hold one side's address fixed |
| cfg_hold_sel | input | 1 | 0 holds source, 1 holds destination |
| beat_valid | output | 1 | Beat addresses valid |
| beat_ready | input | 1 | Consumer accepts the beat |
| beat_src | output | 32 | Source address of the beat |
| beat_dst | output | 32 | Destination address of the beat |
| beat_src_size | output | 2 | Source width code of the beat |
| beat_dst_size | output | 2 | Destination width code of the beat |
| frag_done | output | 1 | Fragment finished pulse |
| blk_done | output | 1 | Block finished pulse |
| txn_done | output | 1 | Transaction finished pulse |
| req_done | output | 1 | Request finished pulse |
| cur_dst | output | 32 | Destination address of the next beat |

## Verification
A request accepted at one edge shows `beat_valid` and the first beat's addresses right after that edge. Every address and counter moves at the edge where a beat handshakes. The done pulses and `req_done` appear right after the edge of the last beat and are gone one cycle later. The bench drives inputs and samples outputs on falling edges. It counts a beat only when valid and ready are both high at that falling edge, and it tallies done pulses until the falling edge where `req_done` is seen. It then checks the coincidence of the final pulses and their removal one falling edge later. For stalled beats, it compares the addresses against the previous falling edge.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    RM_FRAG  = 2'd0,
    RM_BLOCK = 2'd1,
    RM_TXN   = 2'd2,
    RM_CHAIN = 2'd3
  } reqmode_e;

  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned LVL_FRAG = 0;
  localparam int unsigned LVL_BLK  = 1;
  localparam int unsigned LVL_TXN  = 2;

  // bytes moved by one beat for a width code
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // hierarchy level at which a request of this mode completes
  function automatic logic [1:0] stop_level(input reqmode_e m);
    case (m)
      RM_FRAG:  return 2'd0;
      RM_BLOCK: return 2'd1;
      default:  return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/dmaseq_level_cnt.sv
module dmaseq_level_cnt #(
  parameter int unsigned CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [2:0]       bytes,
  input  logic [CNT_W-1:0] len,
  input  logic             force_end,
  output logic             end_now
);
  localparam int unsigned SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum;

  assign sum     = {1'b0, cnt_q} + SUM_W'(bytes);
  assign end_now = force_end || (sum >= {1'b0, len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (advance) cnt_q <= end_now ? '0 : sum[CNT_W-1:0];
  end

  // R5: a unit never carries a byte count at or beyond its length
  p_cnt_below_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) || (cnt_q < len));

endmodule

// File: rtl/dmaseq_addr_gen.sv
module dmaseq_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [STEP_W-1:0] src_step,
  input  logic [STEP_W-1:0] dst_step,
  input  logic              hold_en,
  input  logic              hold_sel,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr
);
  logic hold_src, hold_dst;

  assign hold_src = hold_en && !hold_sel;
  assign hold_dst = hold_en &&  hold_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr <= '0;
      dst_addr <= '0;
    end else if (load) begin
      src_addr <= src_base;
      dst_addr <= dst_base;
    end else if (advance) begin
      if (!hold_src) src_addr <= src_addr + ADDR_W'(src_step);
      if (!hold_dst) dst_addr <= dst_addr + ADDR_W'(dst_step);
    end
  end

  p_hold_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    advance && hold_src |=> $stable(src_addr));
  p_hold_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    advance && hold_dst |=> $stable(dst_addr));

endmodule

// File: rtl/dmaseq_req_ctl.sv
module dmaseq_req_ctl
  import dmaseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  reqmode_e req_mode,
  output logic     req_ready,
  output logic     running,
  output logic     txn_start,
  input  logic     beat_ready,
  output logic     beat_fire,
  input  logic     frag_end,
  input  logic     blk_end,
  input  logic     txn_end,
  output logic     frag_done,
  output logic     blk_done,
  output logic     txn_done,
  output logic     req_done
);
  logic     running_q, txn_active_q, accept, complete;
  reqmode_e mode_q;
  logic [1:0] reached;

  assign running   = running_q;
  assign req_ready = !running_q;
  assign accept    = req_valid && !running_q;
  assign txn_start = accept && !txn_active_q;
  assign beat_fire = running_q && beat_ready;
  assign reached   = txn_end ? 2'd2 : (blk_end ? 2'd1 : 2'd0);
  assign complete  = beat_fire && frag_end && (reached >= stop_level(mode_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q    <= 1'b0;
      txn_active_q <= 1'b0;
      mode_q       <= RM_FRAG;
      frag_done    <= 1'b0;
      blk_done     <= 1'b0;
      txn_done     <= 1'b0;
      req_done     <= 1'b0;
    end else begin
      if (accept)        running_q <= 1'b1;
      else if (complete) running_q <= 1'b0;
      if (txn_start)                 txn_active_q <= 1'b1;
      else if (beat_fire && txn_end) txn_active_q <= 1'b0;
      if (accept) mode_q <= req_mode;
      frag_done <= beat_fire && frag_end;
      blk_done  <= beat_fire && blk_end;
      txn_done  <= beat_fire && txn_end;
      req_done  <= complete;
    end
  end

  // R2: completion respects the granularity that was requested
  p_req_block_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_done && (mode_q == RM_BLOCK) |-> blk_done);
  p_req_txn_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_done && (mode_q == RM_TXN || mode_q == RM_CHAIN) |-> txn_done);

endmodule

// File: rtl/dma_hier_seq.sv
module dma_hier_seq
  import dmaseq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned STEP_W     = 16,
  parameter int unsigned FRAG_LEN_W = 17,
  parameter int unsigned BLK_LEN_W  = 17,
  parameter int unsigned TXN_LEN_W  = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_mode,
  input  logic [ADDR_W-1:0]   cfg_src_base,
  input  logic [ADDR_W-1:0]   cfg_dst_base,
  input  logic [1:0]          cfg_src_width,
  input  logic [1:0]          cfg_dst_width,
  input  logic [2*STEP_W-1:0] cfg_step,
  input  logic [FRAG_LEN_W-1:0] cfg_frag_len,
  input  logic [BLK_LEN_W-1:0]  cfg_blk_len,
  input  logic [TXN_LEN_W-1:0]  cfg_txn_len,
  input  logic                cfg_hold_en,
  input  logic                cfg_hold_sel,
  output logic                beat_valid,
  input  logic                beat_ready,
  output logic [ADDR_W-1:0]   beat_src,
  output logic [ADDR_W-1:0]   beat_dst,
  output logic [1:0]          beat_src_size,
  output logic [1:0]          beat_dst_size,
  output logic                frag_done,
  output logic                blk_done,
  output logic                txn_done,
  output logic                req_done,
  output logic [ADDR_W-1:0]   cur_dst
);
  localparam int unsigned FB_W  = (FRAG_LEN_W > BLK_LEN_W) ? FRAG_LEN_W : BLK_LEN_W;
  localparam int unsigned CNT_W = (TXN_LEN_W > FB_W) ? TXN_LEN_W : FB_W;

  // configuration captured when a transaction opens
  logic [FRAG_LEN_W-1:0] frag_len_q;
  logic [BLK_LEN_W-1:0]  blk_len_q;
  logic [TXN_LEN_W-1:0]  txn_len_q;
  logic [1:0]            src_w_q, dst_w_q;
  logic [2*STEP_W-1:0]   step_q;
  logic                  hold_en_q, hold_sel_q;

  logic running, txn_start, beat_fire;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [2:0] beat_bytes;

  logic [CNT_W-1:0] lvl_len [NUM_LVL];
  logic             lvl_end [NUM_LVL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frag_len_q <= '0;
      blk_len_q  <= '0;
      txn_len_q  <= '0;
      src_w_q    <= '0;
      dst_w_q    <= '0;
      step_q     <= '0;
      hold_en_q  <= 1'b0;
      hold_sel_q <= 1'b0;
    end else if (txn_start) begin
      frag_len_q <= cfg_frag_len;
      blk_len_q  <= cfg_blk_len;
      txn_len_q  <= cfg_txn_len;
      src_w_q    <= cfg_src_width;
      dst_w_q    <= cfg_dst_width;
      step_q     <= cfg_step;
      hold_en_q  <= cfg_hold_en;
      hold_sel_q <= cfg_hold_sel;
    end
  end

  assign beat_bytes        = width_bytes(src_w_q);
  assign lvl_len[LVL_FRAG] = CNT_W'(frag_len_q);
  assign lvl_len[LVL_BLK]  = CNT_W'(blk_len_q);
  assign lvl_len[LVL_TXN]  = CNT_W'(txn_len_q);

  // each level is forced to end when the level above it ends
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic force_w;
    if (g == NUM_LVL - 1) begin : g_outer
      assign force_w = 1'b0;
    end else begin : g_inner
      assign force_w = lvl_end[g+1];
    end
    dmaseq_level_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (txn_start),
      .advance   (beat_fire),
      .bytes     (beat_bytes),
      .len       (lvl_len[g]),
      .force_end (force_w),
      .end_now   (lvl_end[g])
    );
  end

  dmaseq_req_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (reqmode_e'(req_mode)),
    .req_ready  (req_ready),
    .running    (running),
    .txn_start  (txn_start),
    .beat_ready (beat_ready),
    .beat_fire  (beat_fire),
    .frag_end   (lvl_end[LVL_FRAG]),
    .blk_end    (lvl_end[LVL_BLK]),
    .txn_end    (lvl_end[LVL_TXN]),
    .frag_done  (frag_done),
    .blk_done   (blk_done),
    .txn_done   (txn_done),
    .req_done   (req_done)
  );

  dmaseq_addr_gen #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (txn_start),
    .advance  (beat_fire),
    .src_base (cfg_src_base),
    .dst_base (cfg_dst_base),
    .src_step (step_q[STEP_W-1:0]),
    .dst_step (step_q[2*STEP_W-1:STEP_W]),
    .hold_en  (hold_en_q),
    .hold_sel (hold_sel_q),
    .src_addr (src_addr),
    .dst_addr (dst_addr)
  );

  assign beat_valid    = running;
  assign beat_src      = src_addr;
  assign beat_dst      = dst_addr;
  assign beat_src_size = src_w_q;
  assign beat_dst_size = dst_w_q;
  assign cur_dst       = dst_addr;

  p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_src) && $stable(beat_dst));
  p_accept_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> beat_valid && !req_ready);
  p_txn_nests_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |-> blk_done);
  p_blk_nests_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> frag_done);
  p_idle_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> !beat_valid && req_ready);

endmodule

// File: tb/tb_dma_hier_seq.sv
module tb_dma_hier_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 9;

  typedef struct packed {
    int mode; int width; int frag; int blk; int txn;
    int sstep; int dstep; int hold_en; int hold_sel;
    int beats; int nf; int nb; int nt; int lsrc; int ldst;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2, 2,  8, 16, 40, 4,  4, 0, 0, 10, 5, 3, 1, 'h1024, 'h8024},
    '{0, 2,  8, 16, 40, 4,  4, 0, 0,  2, 1, 0, 0, 'h1004, 'h8004},
    '{1, 1,  4,  8, 20, 2,  2, 0, 0,  4, 2, 1, 0, 'h1006, 'h8006},
    '{2, 0,  3,  5,  7, 1,  1, 0, 0,  7, 3, 2, 1, 'h1006, 'h8006},
    '{3, 2,  4,  4, 12, 4, 16, 0, 0,  3, 3, 3, 1, 'h1008, 'h8020},
    '{2, 2,  8,  8,  8, 4,  4, 1, 0,  2, 1, 1, 1, 'h1000, 'h8004},
    '{2, 2,  8,  8,  8, 4,  4, 1, 1,  2, 1, 1, 1, 'h1004, 'h8000},
    '{2, 3,  4,  8,  8, 8,  8, 0, 0,  2, 2, 1, 1, 'h1008, 'h8008},
    '{0, 2, 16,  4,  8, 4,  4, 0, 0,  1, 1, 1, 0, 'h1000, 'h8000}
  };

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [1:0] req_mode;
  logic [31:0] cfg_src_base, cfg_dst_base;
  logic [1:0] cfg_src_width, cfg_dst_width;
  logic [31:0] cfg_step;
  logic [16:0] cfg_frag_len, cfg_blk_len;
  logic [27:0] cfg_txn_len;
  logic cfg_hold_en, cfg_hold_sel;
  logic beat_valid, beat_ready;
  logic [31:0] beat_src, beat_dst, cur_dst;
  logic [1:0] beat_src_size, beat_dst_size;
  logic frag_done, blk_done, txn_done, req_done;

  dma_hier_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_src_width(cfg_src_width), .cfg_dst_width(cfg_dst_width), .cfg_step(cfg_step),
    .cfg_frag_len(cfg_frag_len), .cfg_blk_len(cfg_blk_len), .cfg_txn_len(cfg_txn_len),
    .cfg_hold_en(cfg_hold_en), .cfg_hold_sel(cfg_hold_sel), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_src(beat_src), .beat_dst(beat_dst),
    .beat_src_size(beat_src_size), .beat_dst_size(beat_dst_size),
    .frag_done(frag_done), .blk_done(blk_done), .txn_done(txn_done),
    .req_done(req_done), .cur_dst(cur_dst)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit wd_hit = 0;

  // results of the last request
  int r_beats, r_nf, r_nb, r_nt, r_stall_err;
  logic [31:0] r_fsrc, r_fdst, r_lsrc, r_ldst;
  logic [1:0] r_ssize, r_dsize;
  bit r_all3, r_rdy_at_done;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !wd_hit) begin
      wd_hit = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected < %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int frag, input int blk, input int txn, input int width,
                         input int sstep, input int dstep, input int hen, input int hsel);
    cfg_frag_len  = 17'(frag);
    cfg_blk_len   = 17'(blk);
    cfg_txn_len   = 28'(txn);
    cfg_src_width = 2'(width);
    cfg_dst_width = 2'(width);
    cfg_step      = {16'(dstep), 16'(sstep)};
    cfg_hold_en   = hen[0];
    cfg_hold_sel  = hsel[0];
  endtask

  task automatic run_req(input int mode, input bit toggle);
    bit finished = 0, stall_prev = 0;
    logic [31:0] st_src = '0, st_dst = '0;
    int guard = 0;
    r_beats = 0; r_nf = 0; r_nb = 0; r_nt = 0; r_stall_err = 0;
    r_all3 = 0; r_rdy_at_done = 0;
    @(negedge clk);
    req_mode = 2'(mode);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!finished && guard < 2000) begin
      beat_ready = toggle ? guard[0] : 1'b1;
      if (stall_prev && !(beat_valid && beat_src == st_src && beat_dst == st_dst))
        r_stall_err++;
      stall_prev = beat_valid && !beat_ready;
      st_src = beat_src; st_dst = beat_dst;
      if (beat_valid && beat_ready) begin
        if (r_beats == 0) begin
          r_fsrc = beat_src; r_fdst = beat_dst;
          r_ssize = beat_src_size; r_dsize = beat_dst_size;
        end
        r_lsrc = beat_src; r_ldst = beat_dst;
        r_beats++;
      end
      if (frag_done) r_nf++;
      if (blk_done)  r_nb++;
      if (txn_done)  r_nt++;
      if (req_done) begin
        finished = 1;
        r_all3 = frag_done && blk_done && txn_done;
        r_rdy_at_done = req_ready;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    beat_ready = 1'b1;
    if (!finished) check(0, "R2 request never completed", guard, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; beat_ready = 1'b1;
    cfg_src_base = 32'h1000; cfg_dst_base = 32'h8000;
    set_cfg(8, 16, 40, 2, 4, 4, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    check(beat_valid == 1'b0, "R1 beat_valid after reset", beat_valid, 0);
    check({frag_done, blk_done, txn_done, req_done} == 4'b0, "R1 done outputs after reset",
          {frag_done, blk_done, txn_done, req_done}, 0);
    check(cur_dst == 32'h0, "R1 cur_dst after reset", cur_dst, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      set_cfg(v.frag, v.blk, v.txn, v.width, v.sstep, v.dstep, v.hold_en, v.hold_sel);
      run_req(v.mode, (i == 2) || (i == 6));
      check(r_beats == v.beats, $sformatf("R2 R4 R5 beats vec %0d", i), r_beats, v.beats);
      check(r_nf == v.nf, $sformatf("R5 fragment dones vec %0d", i), r_nf, v.nf);
      check(r_nb == v.nb, $sformatf("R5 block dones vec %0d", i), r_nb, v.nb);
      check(r_nt == v.nt, $sformatf("R5 transaction dones vec %0d", i), r_nt, v.nt);
      check(r_fsrc == 32'h1000 && r_fdst == 32'h8000, $sformatf("R3 first beat vec %0d", i),
            {r_fsrc, r_fdst}, 64'h0000100000008000);
      check(r_lsrc == 32'(v.lsrc), $sformatf("R3 R7 last src vec %0d", i), r_lsrc, v.lsrc);
      check(r_ldst == 32'(v.ldst), $sformatf("R3 R7 last dst vec %0d", i), r_ldst, v.ldst);
      check(r_stall_err == 0, $sformatf("R9 stalled beat moved vec %0d", i), r_stall_err, 0);
      if (v.nt == 0) run_req(2, 1'b0);
    end

    // final beat raises all three pulses, each for one cycle
    set_cfg(8, 16, 40, 2, 4, 4, 0, 0);
    run_req(2, 1'b0);
    check(r_all3, "R6 all done pulses on final beat", r_all3, 1);
    check(r_rdy_at_done, "R9 req_ready with req_done", r_rdy_at_done, 1);
    @(negedge clk);
    check({frag_done, blk_done, txn_done, req_done} == 4'b0, "R6 pulses last one cycle",
          {frag_done, blk_done, txn_done, req_done}, 0);

    // progress output
    run_req(0, 1'b0);
    check(cur_dst == 32'h8008, "R10 cur_dst after one fragment", cur_dst, 32'h8008);
    run_req(2, 1'b0);
    check(cur_dst == 32'h8028, "R10 cur_dst after transaction", cur_dst, 32'h8028);

    // continuation and mid-transaction configuration changes
    set_cfg(8, 16, 40, 2, 4, 4, 0, 0);
    cfg_dst_width = 2'd1;
    run_req(0, 1'b0);
    check(r_ssize == 2'd2 && r_dsize == 2'd1, "R11 beat size codes",
          {r_ssize, r_dsize}, 4'b1001);
    check(r_beats == 2, "R4 source width sets bytes per beat", r_beats, 2);
    cfg_src_base = 32'h5000; cfg_step = {16'd8, 16'd8}; cfg_frag_len = 17'd4;
    run_req(0, 1'b0);
    check(r_beats == 2, "R8 fragment length unchanged mid-transaction", r_beats, 2);
    check(r_fsrc == 32'h1008, "R8 second fragment resumes", r_fsrc, 32'h1008);
    check(r_lsrc == 32'h100C, "R8 step unchanged mid-transaction", r_lsrc, 32'h100C);
    run_req(1, 1'b0);
    check(r_beats == 4 && r_nb == 1, "R2 block request runs one block", r_beats, 4);
    check(r_fsrc == 32'h1010 && r_lsrc == 32'h101C, "R8 block continues", r_lsrc, 32'h101C);
    run_req(2, 1'b0);
    check(r_beats == 2 && r_nt == 1, "R2 transaction request finishes rest", r_beats, 2);
    check(r_lsrc == 32'h1024, "R3 last beat of transaction", r_lsrc, 32'h1024);
    run_req(0, 1'b0);
    check(r_fsrc == 32'h5000, "R8 new transaction takes new base", r_fsrc, 32'h5000);
    check(r_beats == 1, "R8 new transaction takes new fragment length", r_beats, 1);
    run_req(2, 1'b0);
    check(r_fsrc == 32'h5008, "R3 new step applied", r_fsrc, 32'h5008);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule